// File: doc/BRIEF.md
# Free-Running Timer with Input Capture

This block is a free-running up-counter with two capture channels. When the run control is high, the count advances by one on every system clock cycle in which the count-tick enable is asserted. After the all-ones value, the next tick returns it to zero. That wrap step raises a one-cycle overflow interrupt and sets an overflow flag. The flag stays set until software pulses a clear strobe. Dropping the run control stops the counter and returns it to zero.

Each capture channel samples an external pin through a two-stage synchronizer. It then looks for the edge kind chosen by that channel's 2-bit select field. When that edge is found, the channel copies the live count into its own capture register and pulses its own interrupt. Captures do not wait for a count tick, and they never disturb the counter. The two channels are fully independent. A typical use is measuring the time between external events by reading the captured counts. The overflow interrupt extends the time base.

Top module: `frt_capture_top`

## Requirements
- R1: While run_i is low, count_o is 0 whatever tick_i does. Lowering run_i returns count_o to 0 at the next clock, and capture registers keep their values.
- R2: While run_i is high, count_o rises by one at each clock where tick_i is high and holds at each clock where tick_i is low.
- R3: A tick while count_o is all ones (16'hFFFF by default) gives count_o = 0 at the next clock. ovf_irq_o is high for exactly that one cycle and is low at all other times.
- R4: ovf_flag_o is 0 after reset. It becomes 1 in the same cycle as the ovf_irq_o pulse and stays 1 until ovf_clr_i is sampled high, which makes it 0 at the next clock.
- R5: When ovf_clr_i is high on the same clock as a wrap, ovf_flag_o becomes 1.
- R6: The select field edge_sel_i[2m+1:2m] for channel m decodes as follows: 00 means no capture, 01 means rising edges, 10 means falling edges and 11 means both edges.
- R7: Suppose a valid edge is applied to cap_in_i[m] just after a clock. Then cap_val_o[16m+15:16m] takes the count_o value seen in the second following cycle, and cap_irq_o[m] is high for exactly the third following cycle.
- R8: A capture register changes only on a valid edge of its own channel. An edge on one channel leaves the other channel's register and interrupt untouched.
- R9: Captures happen even when tick_i is low, and they do not change count_o.
- R10: After reset, count_o, all capture registers, all interrupts and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one clock per count step |
| run_i | input | 1 | Counter run control; low holds the count at 0 |
| ovf_clr_i | input | 1 | Strobe that clears the overflow flag |
| cap_in_i | input | NCH | Asynchronous capture pins, one per channel |
| edge_sel_i | input | 2*NCH | Edge select, two bits per channel |
| count_o | output | W | Live counter value |
| cap_val_o | output | NCH*W | Capture registers, channel m at bits [W*m+W-1:W*m] |
| cap_irq_o | output | NCH | Capture interrupt pulses |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
Channel 0 is driven through a rising and then a falling pin transition under each of the four select codes. These eight cases show whether the decoder confuses the rising and falling terms or swaps the two select bits. A capture with the tick held low separates capture latching from counting, and a transition on channel 1 alone exposes any crosstalk between channels. The counter is driven with an irregular tick pattern, and a full wrap is run with the clear strobe coinciding with the overflow. This shows whether the wrap is one cycle late and whether set takes priority over clear on the flag.

// File: rtl/frt_pkg.sv
package frt_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // bit 0 enables rising detection, bit 1 enables falling detection
  function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
    return (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] step(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  logic [W-1:0] cnt_q;

  assign wrap_o  = run_i & tick_i & (cnt_q == MAXV);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= step(cnt_q);
  end
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic clr_i,
  output logic irq_o,
  output logic flag_o
);
  logic irq_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= wrap_i;
      if (wrap_i)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/frt_cap_chan.sv
module frt_cap_chan
  import frt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  edge_sel_e    sel_i,
  input  logic [W-1:0] count_i,
  output logic         hit_o,
  output logic [W-1:0] val_o,
  output logic         irq_o
);
  localparam int SYNC = 2;

  logic [SYNC:0] sh_q;   // SYNC synchronizer stages plus one history stage
  logic [W-1:0]  val_q;
  logic          irq_q;

  assign hit_o = edge_hit(sel_i, sh_q[SYNC-1], sh_q[SYNC]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      val_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sh_q  <= {sh_q[SYNC-1:0], pin_i};
      irq_q <= hit_o;
      if (hit_o) val_q <= count_i;
    end
  end

  assign val_o = val_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/frt_capture_top.sv
module frt_capture_top
  import frt_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ovf_clr_i,
  input  logic [NCH-1:0]   cap_in_i,
  input  logic [2*NCH-1:0] edge_sel_i,
  output logic [W-1:0]     count_o,
  output logic [NCH*W-1:0] cap_val_o,
  output logic [NCH-1:0]   cap_irq_o,
  output logic             ovf_irq_o,
  output logic             ovf_flag_o
);
  logic           wrap_evt;
  logic [NCH-1:0] cap_hit;

  frt_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run_i),
    .count_o(count_o),
    .wrap_o (wrap_evt)
  );

  frt_ovf_flag u_ovf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap_evt),
    .clr_i (ovf_clr_i),
    .irq_o (ovf_irq_o),
    .flag_o(ovf_flag_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    frt_cap_chan #(.W(W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_in_i[g]),
      .sel_i  (edge_sel_e'(edge_sel_i[2*g +: 2])),
      .count_i(count_o),
      .hit_o  (cap_hit[g]),
      .val_o  (cap_val_o[g*W +: W]),
      .irq_o  (cap_irq_o[g])
    );
  end
endmodule

// File: rtl/frt_capture_chk.sv
module frt_capture_chk #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_i,
  input logic             ovf_clr_i,
  input logic [W-1:0]     count_i,
  input logic             wrap_evt_i,
  input logic [NCH-1:0]   cap_hit_i,
  input logic [NCH*W-1:0] cap_val_i,
  input logic [NCH-1:0]   cap_irq_i,
  input logic             ovf_irq_i,
  input logic             ovf_flag_i
);
  localparam logic [W-1:0] MAXV = '1;

  p_run_low_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (count_i == '0));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && count_i != MAXV) |=> (count_i == W'($past(count_i) + W'(1))));

  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(count_i));

  p_ovf_at_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |-> (count_i == '0 && $past(count_i) == MAXV));

  p_ovf_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |=> !ovf_irq_i);

  p_flag_with_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |-> ovf_flag_i);

  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !wrap_evt_i) |=> !ovf_flag_i);

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt_i |=> ovf_flag_i);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_cap_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_hit_i[g] |=> (cap_irq_i[g] && cap_val_i[g*W +: W] == $past(count_i)));

    p_irq_from_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_irq_i[g] |-> $past(cap_hit_i[g]));

    p_cap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_irq_i[g] |-> $stable(cap_val_i[g*W +: W]));
  end
endmodule

bind frt_capture_top frt_capture_chk #(.W(W), .NCH(NCH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .run_i     (run_i),
  .ovf_clr_i (ovf_clr_i),
  .count_i   (count_o),
  .wrap_evt_i(wrap_evt),
  .cap_hit_i (cap_hit),
  .cap_val_i (cap_val_o),
  .cap_irq_i (cap_irq_o),
  .ovf_irq_i (ovf_irq_o),
  .ovf_flag_i(ovf_flag_o)
);

// File: tb/frt_capture_top_tb.sv
`timescale 1ns/1ps
module frt_capture_top_tb_top;
  localparam int W = 16;
  localparam int NCH = 2;
  localparam logic [1:0] SEL_NONE = 2'b00, SEL_RISE = 2'b01, SEL_FALL = 2'b10, SEL_BOTH = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, clr = 1'b0;
  logic [NCH-1:0] cap_in = '0;
  logic [2*NCH-1:0] sel = '0;
  logic [W-1:0] count_o;
  logic [NCH*W-1:0] cap_val;
  logic [NCH-1:0] cap_irq;
  logic ovf_irq, ovf_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frt_capture_top #(.W(W), .NCH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .ovf_clr_i(clr),
    .cap_in_i(cap_in), .edge_sel_i(sel), .count_o(count_o), .cap_val_o(cap_val),
    .cap_irq_o(cap_irq), .ovf_irq_o(ovf_irq), .ovf_flag_o(ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] val_of(input int ch);
    return cap_val[ch*W +: W];
  endfunction

  // Called at a falling edge. Applies one pin transition and follows it for four cycles.
  task automatic cap_edge(input int ch, input logic lvl, input bit expect_hit, input string req);
    logic [W-1:0] exp_v, old_v, other_old;
    int oc = 1 - ch;
    old_v = val_of(ch);
    other_old = val_of(oc);
    cap_in[ch] = lvl;
    @(negedge clk);
    @(negedge clk);
    exp_v = count_o;
    chk(cap_irq[ch] == 1'b0, req, "irq early", 32'(cap_irq[ch]), 0);
    @(negedge clk);
    if (expect_hit) begin
      chk(cap_irq[ch] == 1'b1, req, "capture irq", 32'(cap_irq[ch]), 1);
      chk(val_of(ch) == exp_v, req, "captured value", 32'(val_of(ch)), 32'(exp_v));
    end else begin
      chk(cap_irq[ch] == 1'b0, req, "no irq", 32'(cap_irq[ch]), 0);
      chk(val_of(ch) == old_v, req, "value held", 32'(val_of(ch)), 32'(old_v));
    end
    chk(cap_irq[oc] == 1'b0, "R8", "other irq", 32'(cap_irq[oc]), 0);
    chk(val_of(oc) == other_old, "R8", "other value", 32'(val_of(oc)), 32'(other_old));
    @(negedge clk);
    chk(cap_irq[ch] == 1'b0, "R7", "irq single cycle", 32'(cap_irq[ch]), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o == '0, "R10", "count", 32'(count_o), 0);
    chk(cap_val == '0, "R10", "capture regs", cap_val[31:0], 0);
    chk(cap_irq == '0 && !ovf_irq, "R10", "irqs", {cap_irq, ovf_irq}, 0);
    chk(ovf_flag == 1'b0, "R10", "flag", 32'(ovf_flag), 0);
  endtask

  task automatic t_counting();
    logic [7:0] pat = 8'b1011_0110;
    logic [W-1:0] exp = '0;
    run = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick = pat[i];
      @(negedge clk);
      exp = exp + W'(pat[i]);
      chk(count_o == exp, "R2", "count step", 32'(count_o), 32'(exp));
    end
    tick = 1'b1;
  endtask

  task automatic t_edges();
    sel = {SEL_NONE, SEL_NONE};
    cap_edge(0, 1'b1, 1'b0, "R6");
    cap_edge(0, 1'b0, 1'b0, "R6");
    sel = {SEL_NONE, SEL_RISE};
    cap_edge(0, 1'b1, 1'b1, "R7");
    cap_edge(0, 1'b0, 1'b0, "R6");
    sel = {SEL_NONE, SEL_FALL};
    cap_edge(0, 1'b1, 1'b0, "R6");
    cap_edge(0, 1'b0, 1'b1, "R6");
    sel = {SEL_NONE, SEL_BOTH};
    cap_edge(0, 1'b1, 1'b1, "R6");
    cap_edge(0, 1'b0, 1'b1, "R6");
    sel = {SEL_RISE, SEL_BOTH};
    cap_edge(1, 1'b1, 1'b1, "R8");
    cap_edge(1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_between_ticks();
    logic [W-1:0] held;
    tick = 1'b0;
    @(negedge clk);
    held = count_o;
    cap_edge(0, 1'b1, 1'b1, "R9");
    chk(val_of(0) == held, "R9", "capture without tick", 32'(val_of(0)), 32'(held));
    chk(count_o == held, "R9", "count undisturbed", 32'(count_o), 32'(held));
    cap_edge(0, 1'b0, 1'b1, "R9");
    tick = 1'b1;
  endtask

  task automatic t_run_gate();
    logic [NCH*W-1:0] kept = cap_val;
    run = 1'b0;
    @(negedge clk);
    chk(count_o == '0, "R1", "count cleared on stop", 32'(count_o), 0);
    repeat (3) @(negedge clk);
    chk(count_o == '0, "R1", "count held while stopped", 32'(count_o), 0);
    chk(cap_val == kept, "R1", "captures kept", cap_val[31:0], kept[31:0]);
    run = 1'b1;
    repeat (3) @(negedge clk);
    chk(count_o == W'(3), "R1", "restart from zero", 32'(count_o), 3);
  endtask

  task automatic t_wrap();
    int early = 0;
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    tick = 1'b1;
    while (count_o != '1) begin
      @(negedge clk);
      if (ovf_irq) early++;
    end
    chk(early == 0, "R3", "no early overflow", 32'(early), 0);
    chk(ovf_flag == 1'b0, "R4", "flag before wrap", 32'(ovf_flag), 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(count_o == '0, "R3", "wrap to zero", 32'(count_o), 0);
    chk(ovf_irq == 1'b1, "R3", "overflow pulse", 32'(ovf_irq), 1);
    chk(ovf_flag == 1'b1, "R5", "set beats clear", 32'(ovf_flag), 1);
    @(negedge clk);
    chk(ovf_irq == 1'b0, "R3", "pulse ends", 32'(ovf_irq), 0);
    chk(count_o == W'(1), "R3", "counting continues", 32'(count_o), 1);
    repeat (4) @(negedge clk);
    chk(ovf_flag == 1'b1, "R4", "flag sticky", 32'(ovf_flag), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(ovf_flag == 1'b0, "R4", "flag cleared", 32'(ovf_flag), 0);
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R4", "flag stays clear", 32'(ovf_flag), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_counting();
    t_edges();
    t_between_ticks();
    t_run_gate();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule